// File: doc/BRIEF.md
# Misaligned Load/Store Splitter

This block takes a single load or store of 1, 2, 4 or 8 bytes at any byte address. It turns the access into requests on two 128-bit memory ports. One port serves the 16-byte lines whose address bit 4 is clear, and the other serves the lines where that bit is set. Every port request carries a byte-select mask with one bit per byte lane, in the usual bus sense that each set bit enables eight data bits.

An access that stays inside one line produces one port request. An access that runs past a line end is split. The bytes below the boundary go to the port of their line, and the rest go to the following line at address plus 16. That line always belongs to the other port. Store bytes are shifted into their lane positions and routed to the matching port. Each port's load data is captured in its own register when that port acknowledges. Once every issued request has been acknowledged, the captured lines are joined, realigned to the access address, and returned as one 64-bit result with a one-cycle completion pulse.

Top module: `mls_splitter`

## Requirements
- R1: `req_size` encodes the access length: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. A select bit k enables data bits [8k+7:8k] of its port. Across both ports, exactly that many select bits are set, one for each accessed byte.
- R2: A line whose address bit 4 is 0 is requested on the even port (`ev_*`), and a line with bit 4 set on the odd port (`od_*`). The port address is the line start, with address bits [3:0] zero.
- R3: Let o be the access address bits [3:0]. The line that holds the first byte gets select bits o up to min(o+len-1, 15). Any remaining bytes go to the next line, at line start plus 16, on the other port, starting from lane 0.
- R4: When the access fits in one line, only one port is requested and the other stays idle.
- R5: On a store, byte i of `req_wdata` appears on the lane for address+i of the port that serves that byte. Lanes that are not selected carry zero, and the port write strobe is 1. On a load the write strobe is 0.
- R6: A port request stays asserted, with its select mask, address and write data unchanged, until that port acknowledges it in the same cycle.
- R7: `resp_valid` pulses for exactly one cycle, and only after every issued port request has been acknowledged. The two ports may acknowledge in any order and after any delay.
- R8: On a load completion, byte i of `resp_rdata` equals memory byte address+i for i < len, and the bytes at i >= len are zero.
- R9: On a store completion, `resp_rdata` is zero.
- R10: `req_ready` is low from the cycle after an access is accepted until its completion pulse. A `req_valid` presented while `req_ready` is low is ignored: it produces no port request and does not change the result of the access in flight.
- R11: After reset, `req_ready` is 1 and `resp_valid`, `ev_req` and `od_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block is idle and accepts an access |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access length code (see R1) |
| req_addr | input | AW | Byte address of the access |
| req_wdata | input | 64 | Store data, byte 0 at the access address |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 64 | Realigned load result |
| ev_req | output | 1 | Even-line port request |
| ev_we | output | 1 | Even port write strobe |
| ev_addr | output | AW | Even port line address |
| ev_sel | output | 16 | Even port byte selects |
| ev_wdata | output | 128 | Even port write data |
| ev_ack | input | 1 | Even port acknowledge |
| ev_rdata | input | 128 | Even port read data, valid with ack |
| od_req | output | 1 | Odd-line port request |
| od_we | output | 1 | Odd port write strobe |
| od_addr | output | AW | Odd port line address |
| od_sel | output | 16 | Odd port byte selects |
| od_wdata | output | 128 | Odd port write data |
| od_ack | input | 1 | Odd port acknowledge |
| od_rdata | input | 128 | Odd port read data, valid with ack |

## Verification
The bound checker watches the port handshakes on every cycle. It checks that each port only ever sees lines of its own parity, that a pending request holds its mask and address until acknowledged, and that no request is issued with an empty mask. It also checks that the completion pulse lasts one cycle with both ports idle, and that no access is accepted while a port request is outstanding. The exact lane placement of the masks, the realignment and zeroing of load bytes, the routing of store bytes across a line boundary, and the refusal of an intruding request depend on the memory contents and the address. Only the bench's sweep over every line offset, length, direction and acknowledge ordering can show those.

// File: rtl/mls_splitter.sv
module mls_splitter #(
  parameter int AW = 32,
  parameter int LINE_BYTES = 16
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_store,
  input  logic [1:0]              req_size,
  input  logic [AW-1:0]           req_addr,
  input  logic [63:0]             req_wdata,
  output logic                    resp_valid,
  output logic [63:0]             resp_rdata,
  output logic                    ev_req,
  output logic                    ev_we,
  output logic [AW-1:0]           ev_addr,
  output logic [LINE_BYTES-1:0]   ev_sel,
  output logic [8*LINE_BYTES-1:0] ev_wdata,
  input  logic                    ev_ack,
  input  logic [8*LINE_BYTES-1:0] ev_rdata,
  output logic                    od_req,
  output logic                    od_we,
  output logic [AW-1:0]           od_addr,
  output logic [LINE_BYTES-1:0]   od_sel,
  output logic [8*LINE_BYTES-1:0] od_wdata,
  input  logic                    od_ack,
  input  logic [8*LINE_BYTES-1:0] od_rdata
);
  localparam int OFFW = $clog2(LINE_BYTES);
  localparam int LW   = 8 * LINE_BYTES;
  localparam int ACC  = 8;

  logic                    busy, st_store, st_par0;
  logic [OFFW-1:0]         st_off;
  logic [2*LINE_BYTES-1:0] st_mask;

  logic [ACC-1:0]          lenmask;
  logic [63:0]             wmasked;

  always_comb begin
    for (int k = 0; k < ACC; k++) begin
      lenmask[k] = (k < (1 << req_size));
      wmasked[8*k +: 8] = (k < (1 << req_size)) ? req_wdata[8*k +: 8] : 8'h00;
    end
  end

  logic                    accept, par0, spill;
  logic [OFFW-1:0]         off;
  logic [2*LINE_BYTES-1:0] mask2;
  logic [2*LW-1:0]         data2;
  logic [AW-1:0]           line0, line1;

  assign accept = req_valid & ~busy;
  assign off    = req_addr[OFFW-1:0];
  assign par0   = req_addr[OFFW];
  assign mask2  = {{(2*LINE_BYTES-ACC){1'b0}}, lenmask} << off;
  assign data2  = {{(2*LW-64){1'b0}}, wmasked} << {off, 3'b000};
  assign spill  = |mask2[2*LINE_BYTES-1:LINE_BYTES];
  assign line0  = {req_addr[AW-1:OFFW], {OFFW{1'b0}}};
  assign line1  = line0 + AW'(LINE_BYTES);

  logic                  p_req [2];
  logic                  p_ack [2];
  logic [LINE_BYTES-1:0] p_sel [2];
  logic [AW-1:0]         p_addr[2];
  logic [LW-1:0]         p_wd  [2];
  logic [LW-1:0]         p_lat [2];
  logic [LW-1:0]         p_rd  [2];

  assign p_ack[0] = ev_ack;
  assign p_ack[1] = od_ack;
  assign p_rd[0]  = ev_rdata;
  assign p_rd[1]  = od_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 2; g++) begin
        p_req[g]  <= 1'b0;
        p_sel[g]  <= '0;
        p_addr[g] <= '0;
        p_wd[g]   <= '0;
        p_lat[g]  <= '0;
      end
    end else begin
      for (int g = 0; g < 2; g++) begin
        if (accept) begin
          if (par0 == (g == 1)) begin
            p_req[g]  <= 1'b1;
            p_sel[g]  <= mask2[LINE_BYTES-1:0];
            p_addr[g] <= line0;
            p_wd[g]   <= data2[LW-1:0];
          end else begin
            p_req[g]  <= spill;
            p_sel[g]  <= mask2[2*LINE_BYTES-1:LINE_BYTES];
            p_addr[g] <= line1;
            p_wd[g]   <= data2[2*LW-1:LW];
          end
        end else if (p_req[g] && p_ack[g]) begin
          p_req[g] <= 1'b0;
          if (!st_store) p_lat[g] <= p_rd[g];
        end
      end
    end
  end

  logic all_acked;
  assign all_acked = (~p_req[0] | p_ack[0]) & (~p_req[1] | p_ack[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      resp_valid <= 1'b0;
      st_store   <= 1'b0;
      st_par0    <= 1'b0;
      st_off     <= '0;
      st_mask    <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        st_store <= req_store;
        st_par0  <= par0;
        st_off   <= off;
        st_mask  <= mask2;
      end else if (busy && all_acked) begin
        busy       <= 1'b0;
        resp_valid <= 1'b1;
      end
    end
  end

  logic [2*LW-1:0] joined, lanes, shifted;
  always_comb begin
    joined = st_par0 ? {p_lat[0], p_lat[1]} : {p_lat[1], p_lat[0]};
    for (int k = 0; k < 2*LINE_BYTES; k++)
      lanes[8*k +: 8] = st_mask[k] ? joined[8*k +: 8] : 8'h00;
  end
  assign shifted    = lanes >> {st_off, 3'b000};
  assign resp_rdata = st_store ? 64'h0 : shifted[63:0];
  assign req_ready  = ~busy;

  assign ev_req   = p_req[0];
  assign ev_we    = st_store;
  assign ev_addr  = p_addr[0];
  assign ev_sel   = p_sel[0];
  assign ev_wdata = p_wd[0];
  assign od_req   = p_req[1];
  assign od_we    = st_store;
  assign od_addr  = p_addr[1];
  assign od_sel   = p_sel[1];
  assign od_wdata = p_wd[1];
endmodule

// File: rtl/mls_splitter_chk.sv
module mls_splitter_chk #(
  parameter int AW = 32,
  parameter int LINE_BYTES = 16
)(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_ready,
  input logic                  resp_valid,
  input logic                  ev_req,
  input logic                  ev_ack,
  input logic [LINE_BYTES-1:0] ev_sel,
  input logic [AW-1:0]         ev_addr,
  input logic                  od_req,
  input logic                  od_ack,
  input logic [LINE_BYTES-1:0] od_sel,
  input logic [AW-1:0]         od_addr
);
  localparam int OFFW = $clog2(LINE_BYTES);

  p_even_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_req |-> !ev_addr[OFFW]);
  p_odd_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    od_req |-> od_addr[OFFW]);
  p_ev_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_req && !ev_ack |=> ev_req && $stable(ev_sel) && $stable(ev_addr));
  p_od_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    od_req && !od_ack |=> od_req && $stable(od_sel) && $stable(od_addr));
  p_ev_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_req |-> ev_sel != '0);
  p_od_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    od_req |-> od_sel != '0);
  p_span_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_req && od_req |-> ($countones(ev_sel) + $countones(od_sel)) <= 8);
  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  p_resp_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !ev_req && !od_req);
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_req || od_req) |-> !req_ready);
endmodule

bind mls_splitter mls_splitter_chk #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
  .ev_req(ev_req), .ev_ack(ev_ack), .ev_sel(ev_sel), .ev_addr(ev_addr),
  .od_req(od_req), .od_ack(od_ack), .od_sel(od_sel), .od_addr(od_addr)
);

// File: tb/mls_splitter_test.sv
module mls_splitter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_store = 1'b0;
  logic [1:0] req_size = '0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, resp_valid;
  logic [63:0] resp_rdata;
  logic ev_req, ev_we, od_req, od_we;
  logic [31:0] ev_addr, od_addr;
  logic [15:0] ev_sel, od_sel;
  logic [127:0] ev_wdata, od_wdata;

  logic ack_a[2];
  logic [127:0] rd_a[2];
  logic req_a[2], we_a[2];
  logic [15:0] sel_a[2];
  logic [31:0] addr_a[2];
  logic [127:0] wd_a[2];

  assign req_a[0] = ev_req;   assign req_a[1] = od_req;
  assign we_a[0] = ev_we;     assign we_a[1] = od_we;
  assign sel_a[0] = ev_sel;   assign sel_a[1] = od_sel;
  assign addr_a[0] = ev_addr; assign addr_a[1] = od_addr;
  assign wd_a[0] = ev_wdata;  assign wd_a[1] = od_wdata;

  mls_splitter uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .ev_req(ev_req), .ev_we(ev_we), .ev_addr(ev_addr), .ev_sel(ev_sel),
    .ev_wdata(ev_wdata), .ev_ack(ack_a[0]), .ev_rdata(rd_a[0]),
    .od_req(od_req), .od_we(od_we), .od_addr(od_addr), .od_sel(od_sel),
    .od_wdata(od_wdata), .od_ack(ack_a[1]), .od_rdata(rd_a[1])
  );

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  int dly[2];
  int cnt[2], nreq[2], n_unst[2];
  logic [15:0] f_sel[2], c_sel[2];
  logic [31:0] f_addr[2], c_addr[2];
  logic [127:0] f_wd[2], c_wd[2];
  logic c_we[2];

  function automatic logic [7:0] memb(input logic [31:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd37;
    return m ^ a[15:8] ^ 8'hC3;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin
      ack_a[p] = 0; rd_a[p] = '0; cnt[p] = 0; nreq[p] = 0; n_unst[p] = 0; dly[p] = 0;
    end
    forever begin
      @(negedge clk);
      for (int p = 0; p < 2; p++) begin
        if (ack_a[p]) begin
          ack_a[p] = 0;
          cnt[p] = 0;
        end else if (req_a[p]) begin
          if (cnt[p] == 0) begin
            f_sel[p] = sel_a[p]; f_addr[p] = addr_a[p]; f_wd[p] = wd_a[p];
          end else if (f_sel[p] != sel_a[p] || f_addr[p] != addr_a[p] || f_wd[p] != wd_a[p])
            n_unst[p]++;
          if (cnt[p] >= dly[p]) begin
            ack_a[p] = 1;
            for (int k = 0; k < 16; k++) rd_a[p][8*k +: 8] = memb(addr_a[p] + k);
            c_sel[p] = sel_a[p]; c_addr[p] = addr_a[p]; c_wd[p] = wd_a[p]; c_we[p] = we_a[p];
            nreq[p]++;
          end else cnt[p]++;
        end
      end
    end
  end

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input bit st,
                        input logic [63:0] wd, input int d0, input int d1, input bit intrude);
    logic [15:0] es[2];
    logic [127:0] ew[2];
    logic [31:0] ea[2];
    logic [63:0] er;
    logic [31:0] ba;
    int nb[2], ub[2], len, p;
    bit got;
    len = 1 << sz;
    er = '0;
    for (int q = 0; q < 2; q++) begin es[q] = '0; ew[q] = '0; ea[q] = '0; end
    for (int i = 0; i < len; i++) begin
      ba = a + i;
      p = int'(ba[4]);
      es[p][ba[3:0]] = 1'b1;
      ew[p][8*ba[3:0] +: 8] = wd[8*i +: 8];
      ea[p] = {ba[31:4], 4'h0};
      er[8*i +: 8] = memb(ba);
    end
    dly[0] = d0; dly[1] = d1;
    nb[0] = nreq[0]; nb[1] = nreq[1]; ub[0] = n_unst[0]; ub[1] = n_unst[1];
    @(negedge clk);
    req_valid = 1; req_store = st; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R10 ready low after accept", 128'(req_ready), 128'(0));
    got = 0;
    for (int t = 0; t < 60 && !got; t++) begin
      @(negedge clk);
      if (resp_valid) got = 1;
      else if (intrude && t == 0) begin
        req_valid = 1; req_store = ~st; req_addr = a ^ 32'h18; req_size = 2'd3;
      end else if (intrude && t == 1) req_valid = 0;
    end
    req_valid = 0;
    chk(got, "R7 completion pulse seen", 128'(got), 128'(1));
    chk(req_ready, "R10 ready back at completion", 128'(req_ready), 128'(1));
    for (int q = 0; q < 2; q++) begin
      chk((nreq[q] - nb[q]) == ((es[q] != 0) ? 1 : 0), "R4 R3 request count per port",
          128'(nreq[q] - nb[q]), 128'((es[q] != 0) ? 1 : 0));
      if (es[q] != 0) begin
        chk(c_sel[q] == es[q], "R1 R3 byte selects", 128'(c_sel[q]), 128'(es[q]));
        chk(c_addr[q] == ea[q], "R2 line address", 128'(c_addr[q]), 128'(ea[q]));
        chk(c_we[q] == st, "R5 write strobe", 128'(c_we[q]), 128'(st));
        chk(n_unst[q] == ub[q], "R6 request held stable", 128'(n_unst[q]), 128'(ub[q]));
        if (st) chk(c_wd[q] == ew[q], "R5 store lanes", c_wd[q], ew[q]);
      end
    end
    if (st) chk(resp_rdata == 64'h0, "R9 store result zero", 128'(resp_rdata), 128'(0));
    else    chk(resp_rdata == er, "R8 load result", 128'(resp_rdata), 128'(er));
    @(negedge clk);
    chk(!resp_valid, "R7 single-cycle pulse", 128'(resp_valid), 128'(0));
    if (intrude) begin
      repeat (3) @(negedge clk);
      chk(!ev_req && !od_req && (nreq[0] + nreq[1] == nb[0] + nb[1] + ((es[0] != 0) ? 1 : 0) + ((es[1] != 0) ? 1 : 0)),
          "R10 request while busy ignored", 128'(nreq[0] + nreq[1]), 128'(nb[0] + nb[1]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] bases[2];
    int idx;
    bases[0] = 32'h0000_2000;
    bases[1] = 32'h7F3C_5A40;
    repeat (3) @(negedge clk);
    chk(req_ready && !resp_valid && !ev_req && !od_req, "R11 reset state",
        128'({req_ready, resp_valid, ev_req, od_req}), 128'(4'b1000));
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !ev_req && !od_req, "R11 idle after reset release",
        128'({req_ready, ev_req, od_req}), 128'(3'b100));
    idx = 0;
    for (int b = 0; b < 2; b++)
      for (int o = 0; o < 32; o++)
        for (int s = 0; s < 4; s++)
          for (int st = 0; st < 2; st++) begin
            access(bases[b] + o, 2'(s), st[0], 64'h0123_4567_89AB_CDEF ^ {8{8'(idx)}},
                   idx % 3, (idx / 3) % 4, 1'b0);
            idx++;
          end
    access(32'h0000_301C, 2'd3, 1'b0, 64'h0, 4, 2, 1'b1);
    access(32'h0000_300B, 2'd3, 1'b1, 64'hFEDC_BA98_7654_3210, 1, 5, 1'b1);
    access(32'h0000_3005, 2'd2, 1'b0, 64'h0, 5, 0, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule